// File: doc/BRIEF.md
# SECDED Hamming Codec

An extended Hamming codec that protects a K-bit information word with single-error correction and double-error detection. The encoder is purely combinational. It takes the data word and builds a code word with three parts: the data bits, a set of Hamming check bits, and one overall parity bit that makes the complete word even. It also outputs the check bits and the parity bit on their own.

The decoder takes a code word that may be damaged. It returns the repaired data word, the syndrome, and three flags: a single error was seen, a double error was seen, and a data bit was repaired. Its pipeline depth is set by a parameter: fully combinational, registered outputs, or registered inputs and outputs. The registered modes use an active-low asynchronous reset and a clock enable that stalls every register.

A second parameter puts the overall parity bit at either the most or the least significant end of the word. A flip of that parity bit alone does not disturb the data, so it is ignored and raises no flag.

Top module: `secded_codec`

## Requirements
- R1: The number of check bits M is the smallest M ≥ 1 with 2^M ≥ M + K + 1, and the Hamming section of the code word has K + M bits, numbered from position 1. Check bits sit at the power-of-two positions and data bits fill the other positions in ascending order (data bit 0 at position 3). `enc_chk_o[j]` equals the bit at position 2^j. The XOR of the positions of all set bits in an encoded word is zero.
- R2: The overall parity bit makes the whole (K+M+1)-bit code word even and is also output on `enc_par_o`. With P0_AT_LSB = 0 it is bit K+M and code bit b holds position b+1. With P0_AT_LSB = 1 it is bit 0 and code bit b holds position b.
- R3: A code word with no flipped bits decodes to the original data, with syndrome 0 and all three flags low.
- R4: A code word with exactly one flipped bit in the Hamming section decodes to the original data. The syndrome equals that bit's position, `dec_sb_o` is 1 and `dec_db_o` is 0.
- R5: A code word in which only the overall parity bit is flipped decodes to the original data, with syndrome 0 and all three flags low.
- R6: A code word with two distinct flipped bits gives `dec_db_o` = 1 and `dec_sb_o` = 0. The syndrome is the XOR of the positions of the flipped Hamming bits, with the parity bit counting as 0. The data are passed on uncorrected.
- R7: `dec_fix_o` is 1 only when a single error is corrected at a data position (not a power of two). It is 0 for a single error at a check position.
- R8: With LATENCY = 0 the decoder outputs follow the input combinationally. With LATENCY = 1 they appear after one rising clock edge. With LATENCY = 2 they appear after two.
- R9: In the registered modes, while `clk_en` is 0 no decoder register updates, so the outputs hold their values.
- R10: In the registered modes, `rst_n` = 0 clears all decoder outputs to 0 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registered decoder modes |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_en | input | 1 | Enables every decoder register update |
| enc_data_i | input | K | Data word to encode |
| enc_code_o | output | K+M+1 | Encoded code word |
| enc_chk_o | output | M | Hamming check bits, bit j for position 2^j |
| enc_par_o | output | 1 | Overall parity bit |
| dec_code_i | input | K+M+1 | Code word to decode |
| dec_data_o | output | K | Corrected data word |
| dec_syn_o | output | M | Syndrome |
| dec_sb_o | output | 1 | Single-bit error seen |
| dec_db_o | output | 1 | Double-bit error seen |
| dec_fix_o | output | 1 | A data bit was repaired |

## Verification
The bench changes inputs just after a falling edge and samples the outputs at the next falling edge.

The encoder outputs are combinational and are checked within the same half cycle. For LATENCY 0 and 1, a decode result is due at the falling edge after one rising edge. For LATENCY 2 it is due one falling edge later.

Each expected result is queued with the rising-edge count at which it falls due. A monitor compares it only at that sample, so a result that comes early or late fails. Three instances run side by side with different latency and parity-bit placement. Stall and reset are checked directly, against held or cleared values.

// File: rtl/secded_pkg.sv
package secded_pkg;

    // Decoder classification of one received code word
    typedef enum logic [1:0] {
        ERR_NONE   = 2'd0,
        ERR_P0     = 2'd1,
        ERR_SINGLE = 2'd2,
        ERR_DOUBLE = 2'd3
    } err_e;

    // Smallest check-bit count covering k data bits
    function automatic int chk_bits(input int k);
        int m;
        m = 1;
        while ((1 << m) < m + k + 1) m = m + 1;
        return m;
    endfunction

    function automatic bit is_pow2(input int p);
        return (p > 0) && ((p & (p - 1)) == 0);
    endfunction

    // Data index held at a non-power-of-two Hamming position
    function automatic int data_idx(input int p);
        return p - $clog2(p + 1) - 1;
    endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc
    import secded_pkg::*;
#(
    parameter  int K         = 8,
    parameter  bit P0_AT_LSB = 1'b0,
    localparam int M         = chk_bits(K),
    localparam int H         = K + M,
    localparam int N         = H + 1
) (
    input  logic [K-1:0] data_i,
    output logic [N-1:0] code_o,
    output logic [M-1:0] chk_o,
    output logic         par_o
);

    logic [H:1] hs;

    always_comb begin
        hs = '0;
        for (int p = 1; p <= H; p++) begin
            if (!is_pow2(p)) hs[p] = data_i[data_idx(p)];
        end
        for (int j = 0; j < M; j++) begin
            logic c;
            c = 1'b0;
            for (int p = 1; p <= H; p++) begin
                if (((p >> j) & 1) == 1) c = c ^ hs[p];
            end
            hs[1 << j] = c;
            chk_o[j]   = c;
        end
    end

    assign par_o = ^hs;

    generate
        if (P0_AT_LSB) begin : g_p0_low
            assign code_o = {hs, par_o};
        end else begin : g_p0_high
            assign code_o = {par_o, hs};
        end
    endgenerate

endmodule

// File: rtl/secded_core.sv
module secded_core
    import secded_pkg::*;
#(
    parameter  int K         = 8,
    parameter  bit P0_AT_LSB = 1'b0,
    localparam int M         = chk_bits(K),
    localparam int H         = K + M,
    localparam int N         = H + 1
) (
    input  logic [N-1:0] code_i,
    output logic [K-1:0] data_o,
    output logic [M-1:0] syn_o,
    output logic         sb_o,
    output logic         db_o,
    output logic         fix_o
);

    logic [H:1]   hs;
    logic [H:1]   hc;
    logic         p0;
    logic         perr;
    err_e         cls;

    generate
        if (P0_AT_LSB) begin : g_p0_low
            assign {hs, p0} = code_i;
        end else begin : g_p0_high
            assign {p0, hs} = code_i;
        end
    endgenerate

    always_comb begin
        syn_o = '0;
        for (int p = 1; p <= H; p++) begin
            if (hs[p]) syn_o = syn_o ^ M'(p);
        end
    end

    assign perr = (^hs) ^ p0;

    always_comb begin
        if (syn_o == '0) cls = perr ? ERR_P0 : ERR_NONE;
        else             cls = perr ? ERR_SINGLE : ERR_DOUBLE;
    end

    always_comb begin
        hc    = hs;
        fix_o = 1'b0;
        for (int p = 1; p <= H; p++) begin
            if (cls == ERR_SINGLE && syn_o == M'(p)) begin
                hc[p] = ~hs[p];
                if (!is_pow2(p)) fix_o = 1'b1;
            end
        end
    end

    always_comb begin
        data_o = '0;
        for (int p = 1; p <= H; p++) begin
            if (!is_pow2(p)) data_o[data_idx(p)] = hc[p];
        end
    end

    assign sb_o = (cls == ERR_SINGLE);
    assign db_o = (cls == ERR_DOUBLE);

endmodule

// File: rtl/secded_stage.sv
module secded_stage #(
    parameter int W  = 8,
    parameter bit EN = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (EN) begin : g_reg
            logic [W-1:0] r;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)  r <= '0;
                else if (en) r <= d;
            end

            assign q = r;

            // R9
            hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !en |=> $stable(q));
        end else begin : g_wire
            logic unused_stage;
            assign q            = d;
            assign unused_stage = ^{clk, rst_n, en};
        end
    endgenerate

endmodule

// File: rtl/secded_codec.sv
module secded_codec
    import secded_pkg::*;
#(
    parameter  int K         = 8,
    parameter  bit P0_AT_LSB = 1'b0,
    parameter  int LATENCY   = 1,
    localparam int M         = chk_bits(K),
    localparam int N         = K + M + 1,
    localparam int RW        = K + M + 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clk_en,
    input  logic [K-1:0] enc_data_i,
    output logic [N-1:0] enc_code_o,
    output logic [M-1:0] enc_chk_o,
    output logic         enc_par_o,
    input  logic [N-1:0] dec_code_i,
    output logic [K-1:0] dec_data_o,
    output logic [M-1:0] dec_syn_o,
    output logic         dec_sb_o,
    output logic         dec_db_o,
    output logic         dec_fix_o
);

    logic [N-1:0]  code_s;
    logic [K-1:0]  cd;
    logic [M-1:0]  cs;
    logic          csb;
    logic          cdb;
    logic          cfix;
    logic [RW-1:0] res_c;
    logic [RW-1:0] res_q;

    secded_enc #(.K(K), .P0_AT_LSB(P0_AT_LSB)) u_enc (
        .data_i (enc_data_i),
        .code_o (enc_code_o),
        .chk_o  (enc_chk_o),
        .par_o  (enc_par_o)
    );

    secded_stage #(.W(N), .EN(LATENCY == 2)) u_in_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (clk_en),
        .d     (dec_code_i),
        .q     (code_s)
    );

    secded_core #(.K(K), .P0_AT_LSB(P0_AT_LSB)) u_core (
        .code_i (code_s),
        .data_o (cd),
        .syn_o  (cs),
        .sb_o   (csb),
        .db_o   (cdb),
        .fix_o  (cfix)
    );

    assign res_c = {cd, cs, csb, cdb, cfix};

    secded_stage #(.W(RW), .EN(LATENCY >= 1)) u_out_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (clk_en),
        .d     (res_c),
        .q     (res_q)
    );

    assign {dec_data_o, dec_syn_o, dec_sb_o, dec_db_o, dec_fix_o} = res_q;

    // R6
    sb_db_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec_sb_o && dec_db_o));

    // R7
    fix_needs_sb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_fix_o |-> dec_sb_o);

    // R5
    zero_syn_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_syn_o == '0) |-> !(dec_sb_o || dec_db_o || dec_fix_o));

    // R2
    enc_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (^enc_code_o) == 1'b0);

endmodule

// File: tb/secded_codec_bench.sv
module secded_codec_bench;

    localparam int CLK_PERIOD = 10;
    localparam int K  = 8;
    localparam int M  = 4;
    localparam int H  = 12;
    localparam int N  = 13;
    localparam int NI = 3;
    localparam int LAT [NI] = '{1, 0, 2};
    localparam bit P0L [NI] = '{1'b0, 1'b1, 1'b1};

    logic         clk    = 1'b0;
    logic         rst_n  = 1'b0;
    logic         en     = 1'b1;
    logic [K-1:0] enc_data = '0;
    logic [N-1:0] enc_code [NI];
    logic [M-1:0] enc_chk  [NI];
    logic         enc_par  [NI];
    logic [N-1:0] dec_code [NI] = '{default: '1};
    logic [K-1:0] dec_data [NI];
    logic [M-1:0] dec_syn  [NI];
    logic         dec_sb   [NI];
    logic         dec_db   [NI];
    logic         dec_fix  [NI];

    always #(CLK_PERIOD / 2) clk = ~clk;

    secded_codec #(.K(K), .P0_AT_LSB(1'b0), .LATENCY(1)) u_secded_codec (
        .clk(clk), .rst_n(rst_n), .clk_en(en), .enc_data_i(enc_data),
        .enc_code_o(enc_code[0]), .enc_chk_o(enc_chk[0]), .enc_par_o(enc_par[0]),
        .dec_code_i(dec_code[0]), .dec_data_o(dec_data[0]), .dec_syn_o(dec_syn[0]),
        .dec_sb_o(dec_sb[0]), .dec_db_o(dec_db[0]), .dec_fix_o(dec_fix[0]));

    secded_codec #(.K(K), .P0_AT_LSB(1'b1), .LATENCY(0)) u_secded_codec_c (
        .clk(clk), .rst_n(rst_n), .clk_en(en), .enc_data_i(enc_data),
        .enc_code_o(enc_code[1]), .enc_chk_o(enc_chk[1]), .enc_par_o(enc_par[1]),
        .dec_code_i(dec_code[1]), .dec_data_o(dec_data[1]), .dec_syn_o(dec_syn[1]),
        .dec_sb_o(dec_sb[1]), .dec_db_o(dec_db[1]), .dec_fix_o(dec_fix[1]));

    secded_codec #(.K(K), .P0_AT_LSB(1'b1), .LATENCY(2)) u_secded_codec_p (
        .clk(clk), .rst_n(rst_n), .clk_en(en), .enc_data_i(enc_data),
        .enc_code_o(enc_code[2]), .enc_chk_o(enc_chk[2]), .enc_par_o(enc_par[2]),
        .dec_code_i(dec_code[2]), .dec_data_o(dec_data[2]), .dec_syn_o(dec_syn[2]),
        .dec_sb_o(dec_sb[2]), .dec_db_o(dec_db[2]), .dec_fix_o(dec_fix[2]));

    typedef struct {
        int           due;
        logic [K-1:0] data;
        logic [M-1:0] syn;
        logic         sb;
        logic         db;
        logic         fix;
        string        tag;
    } exp_t;

    exp_t q0[$];
    exp_t q1[$];
    exp_t q2[$];

    int tick   = 0;
    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always @(posedge clk) tick <= tick + 1;

    task automatic chk_eq(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Hamming position held by code bit b; 0 marks the overall parity bit
    function automatic int hpos(int b, bit lsb);
        if (lsb) return b;
        return (b == N - 1) ? 0 : b + 1;
    endfunction

    function automatic bit is_p2(int p);
        return (p & (p - 1)) == 0;
    endfunction

    function automatic int didx(int p);
        int c = 0;
        for (int q = 1; q < p; q++) if (!is_p2(q)) c++;
        return c;
    endfunction

    function automatic logic [14:0] outs(int i);
        return {dec_data[i], dec_syn[i], dec_sb[i], dec_db[i], dec_fix[i]};
    endfunction

    task automatic check_enc(int i);
        logic [H:1]   hs;
        logic         p0b;
        logic [K-1:0] got;
        logic [M-1:0] chk_exp;
        int           syn;
        hs  = '0;
        p0b = 1'b0;
        syn = 0;
        for (int b = 0; b < N; b++) begin
            int p = hpos(b, P0L[i]);
            if (p == 0) p0b = enc_code[i][b];
            else        hs[p] = enc_code[i][b];
        end
        for (int p = 1; p <= H; p++) begin
            if (hs[p]) syn = syn ^ p;
            if (!is_p2(p)) got[didx(p)] = hs[p];
        end
        for (int j = 0; j < M; j++) chk_exp[j] = hs[1 << j];
        chk_eq("R1", $sformatf("inst%0d data layout", i), 32'(got), 32'(enc_data));
        chk_eq("R1", $sformatf("inst%0d encoded syndrome", i), 32'(syn), 32'd0);
        chk_eq("R1", $sformatf("inst%0d check bits", i), 32'(enc_chk[i]), 32'(chk_exp));
        chk_eq("R2", $sformatf("inst%0d even parity", i), 32'(^enc_code[i]), 32'd0);
        chk_eq("R2", $sformatf("inst%0d parity bit", i), 32'(enc_par[i]), 32'(p0b));
    endtask

    task automatic push(int i, exp_t e);
        case (i)
            0:       q0.push_back(e);
            1:       q1.push_back(e);
            default: q2.push_back(e);
        endcase
    endtask

    // nf = number of flipped code bits (0..2), b1/b2 = code bit indices
    task automatic apply(logic [K-1:0] d, int nf, int b1, int b2, string ptag);
        @(negedge clk);
        #1 enc_data = d;
        #1;
        for (int i = 0; i < NI; i++) begin
            logic [N-1:0] cw;
            exp_t e;
            int p1;
            int p2;
            check_enc(i);
            cw = enc_code[i];
            if (nf >= 1) cw[b1] = ~cw[b1];
            if (nf == 2) cw[b2] = ~cw[b2];
            dec_code[i] = cw;
            p1 = (nf >= 1) ? hpos(b1, P0L[i]) : 0;
            p2 = (nf == 2) ? hpos(b2, P0L[i]) : 0;
            e.due  = tick + 1 + ((LAT[i] == 2) ? 1 : 0);
            e.data = d;
            e.syn  = 4'(p1 ^ p2);
            e.sb   = (nf == 1) && (p1 != 0);
            e.db   = (nf == 2);
            e.fix  = e.sb && !is_p2(p1);
            if (nf == 2) begin
                if (p1 != 0 && !is_p2(p1)) e.data[didx(p1)] = ~e.data[didx(p1)];
                if (p2 != 0 && !is_p2(p2)) e.data[didx(p2)] = ~e.data[didx(p2)];
            end
            if (nf == 0)      e.tag = {ptag, "R3"};
            else if (nf == 2) e.tag = {ptag, "R6"};
            else if (p1 == 0) e.tag = {ptag, "R5"};
            else              e.tag = {ptag, "R4 R7"};
            push(i, e);
        end
    endtask

    task automatic drive_raw(logic [K-1:0] d);
        @(negedge clk);
        #1 enc_data = d;
        #1;
        for (int i = 0; i < NI; i++) dec_code[i] = enc_code[i];
    endtask

    task automatic cmp(int i, exp_t e);
        chk_eq(e.due == tick ? e.tag : {e.tag, " R8"},
               $sformatf("inst%0d {data,syn,sb,db,fix} at tick %0d due %0d", i, tick, e.due),
               32'(outs(i)), 32'({e.data, e.syn, e.sb, e.db, e.fix}));
    endtask

    // Monitor: compare each expected item at the sample it falls due
    always @(negedge clk) begin
        exp_t e;
        if (q0.size() > 0 && q0[0].due <= tick) begin e = q0.pop_front(); cmp(0, e); end
        if (q1.size() > 0 && q1[0].due <= tick) begin e = q1.pop_front(); cmp(1, e); end
        if (q2.size() > 0 && q2[0].due <= tick) begin e = q2.pop_front(); cmp(2, e); end
    end

    initial begin
        // R10: reset state of registered instances with a nonzero input
        repeat (3) @(negedge clk);
        chk_eq("R10", "inst0 outputs in reset", 32'(outs(0)), 32'd0);
        chk_eq("R10", "inst2 outputs in reset", 32'(outs(2)), 32'd0);
        @(negedge clk) rst_n = 1'b1;
        drive_raw('0);
        repeat (3) @(negedge clk);

        // R3: clean words
        apply(8'h00, 0, 0, 0, "");
        apply(8'hFF, 0, 0, 0, "");
        apply(8'hA5, 0, 0, 0, "");
        apply(8'h3C, 0, 0, 0, "");

        // R4 R5 R7: every single-bit flip position
        for (int b = 0; b < N; b++) apply(8'h5A ^ 8'(b * 7), 1, b, 0, "");

        // R6: double flips, some including the parity bit
        apply(8'h96, 2, 0, 1, "");
        apply(8'h21, 2, 2, 7, "");
        apply(8'hE7, 2, 0, 12, "");
        apply(8'h0F, 2, 5, 11, "");
        apply(8'hC3, 2, 3, 4, "");
        apply(8'h70, 2, 1, 12, "");

        // R8: back-to-back distinct words
        apply(8'h01, 0, 0, 0, "R8 ");
        apply(8'h80, 1, 6, 0, "R8 ");
        apply(8'h7E, 0, 0, 0, "R8 ");
        apply(8'hB4, 2, 8, 9, "R8 ");
        repeat (4) @(negedge clk);
        chk_eq("R8", "queues drained", 32'(q0.size() + q1.size() + q2.size()), 32'd0);

        // R9: stall holds registered outputs
        drive_raw(8'h11);
        repeat (3) @(negedge clk);
        chk_eq("R9", "inst0 before stall", 32'(dec_data[0]), 32'h11);
        chk_eq("R9", "inst2 before stall", 32'(dec_data[2]), 32'h11);
        @(negedge clk) en = 1'b0;
        drive_raw(8'hEE);
        repeat (3) @(negedge clk);
        chk_eq("R9", "inst0 held", 32'(outs(0)), 32'({8'h11, 4'h0, 3'b000}));
        chk_eq("R9", "inst2 held", 32'(outs(2)), 32'({8'h11, 4'h0, 3'b000}));
        chk_eq("R9", "inst1 combinational", 32'(dec_data[1]), 32'hEE);
        @(negedge clk) en = 1'b1;
        repeat (3) @(negedge clk);
        chk_eq("R9", "inst0 resumed", 32'(dec_data[0]), 32'hEE);
        chk_eq("R9", "inst2 resumed", 32'(dec_data[2]), 32'hEE);

        // R10: asynchronous clear between edges
        @(negedge clk);
        #2 rst_n = 1'b0;
        #1;
        chk_eq("R10", "inst0 async clear", 32'(outs(0)), 32'd0);
        chk_eq("R10", "inst2 async clear", 32'(outs(2)), 32'd0);
        @(negedge clk) rst_n = 1'b1;
        repeat (2) @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R8: actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule